// File: doc/BRIEF.md
# Abstract Register Command Sequencer

This block accepts a 32-bit abstract debug command and turns each accepted register-access request into a two-word instruction sequence. The sequence sits in a small abstract instruction buffer that a halted hart runs from debug mode. Slot 0 moves one integer register to or from a fixed debug data location, addressed by a 12-bit immediate off x0. Slot 1 either ends the sequence with a breakpoint or jumps forward into the program buffer, so that code the debugger placed there runs afterwards.

A command is accepted only when the error field is clear and no hart still holds an unacknowledged go flag. An accepted command writes both slots and raises the go flag of the selected hart. A refused command sets the error field and leaves the buffer as it was. The error field stays set until the debugger pulses the clear input. The jump offset is derived from parameters that describe the buffer layout.

Top module: `abs_cmd_seq`

## Requirements
- R1: After reset, slot 0 holds the no-op 0x00000013, slot 1 holds ebreak 0x00100073, the error field is 0 and all go flags are 0.
- R2: A command whose bits [31:24] are not zero is refused. The error field becomes 2 (not supported), the slots are unchanged and no go flag rises.
- R3: With the transfer bit (bit 17) set, only register numbers (bits [15:0]) from 0x1000 to 0x101F are accepted, and the target is x(number − 0x1000). Any other number gives error 2 with no slot change.
- R4: With transfer set, size code (bits [22:20]) 2 selects a 32-bit access (funct3 010) and 3 selects a 64-bit access (funct3 011). Any other code gives error 2 with no slot change.
- R5: With transfer set, write bit (bit 16) = 1 puts a load (opcode 0000011) from the data immediate off x0 into the target register in slot 0. Write bit = 0 puts a store (opcode 0100011) of the target register to that immediate off x0 there.
- R6: When the post-execute bit (bit 18) is set, slot 1 holds jal x0 with offset 4·ABS_WORDS − 4 (0x0040006F with the default layout). When it is clear, slot 1 holds ebreak 0x00100073.
- R7: With transfer clear, slot 0 holds the no-op 0x00000013, and the size and register number are ignored.
- R8: An accepted command sets the go flag of the hart given by hart_sel one cycle later. A go_ack bit clears the matching flag. At most one go flag is set at a time.
- R9: A command that arrives while any go flag is set is refused. The error field becomes 1 (busy) if it was 0, and the slots are unchanged.
- R10: While the error field is nonzero, commands are ignored. A pulse on err_clr returns the field to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word is presented this cycle |
| cmd_word | input | 32 | Abstract command |
| hart_sel | input | HART_W | Currently selected hart |
| go_ack | input | NHART | Per-hart acknowledge that clears the go flag |
| err_clr | input | 1 | Clears the error field |
| abs_slot0 | output | 32 | Abstract buffer word 0 |
| abs_slot1 | output | 32 | Abstract buffer word 1 |
| cmderr | output | 3 | Error field: 0 none, 1 busy, 2 not supported |
| go_flags | output | NHART | Per-hart go flags |

## Verification
The assertions check on every cycle that go flags never show more than one hart, that a go flag rises only from a clean error state, that busy or error-blocked commands leave both slots untouched, and that an accepted command leaves only legal opcodes in the slots. Only the bench scenarios can show the exact encodings: register index, funct3 split, immediate placement and jump offset. The same holds for the range edges 0x0FFF/0x1000/0x101F/0x1020, the rejected size codes and the error-clear sequencing. Each of these is compared against a behavioural model on every clock.

// File: rtl/abs_cmd_pkg.sv
package abs_cmd_pkg;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_NOTSUP = 3'd2
    } cmderr_e;

    // Field layout of the incoming command; positions are decoded.
    typedef struct packed {
        logic [7:0]  ctype;
        logic        rsv_hi;
        logic [2:0]  size;
        logic        rsv_lo;
        logic        post;
        logic        xfer;
        logic        wr;
        logic [15:0] regno;
    } cmd_fields_t;

    typedef struct packed {
        logic       ok;
        logic [4:0] rd;
        logic       dword;
        logic       wr;
        logic       xfer;
        logic       post;
    } dec_t;

    localparam logic [6:0]  OPC_LOAD  = 7'b0000011;
    localparam logic [6:0]  OPC_STORE = 7'b0100011;
    localparam logic [6:0]  OPC_JAL   = 7'b1101111;
    localparam logic [31:0] INSN_NOP  = 32'h0000_0013;
    localparam logic [31:0] INSN_EBRK = 32'h0010_0073;

    function automatic logic [31:0] enc_load(input logic [4:0] rd,
                                             input logic dword,
                                             input logic [11:0] imm);
        return {imm, 5'd0, 2'b01, dword, rd, OPC_LOAD};
    endfunction

    function automatic logic [31:0] enc_store(input logic [4:0] rs,
                                              input logic dword,
                                              input logic [11:0] imm);
        return {imm[11:5], rs, 5'd0, 2'b01, dword, imm[4:0], OPC_STORE};
    endfunction

    function automatic logic [31:0] enc_jal0(input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], 5'd0, OPC_JAL};
    endfunction

endpackage

// File: rtl/abs_cmd_decode.sv
module abs_cmd_decode
    import abs_cmd_pkg::*;
#(
    parameter logic [15:0] REG_BASE = 16'h1000,
    parameter int          NUM_REGS = 32
) (
    input  logic [31:0] cmd_word,
    output dec_t        dec
);
    localparam logic [16:0] REG_END = {1'b0, REG_BASE} + 17'(NUM_REGS);

    cmd_fields_t f;
    logic        in_range;
    logic        size_ok;
    logic [15:0] offs;
    logic        unused_rsv;

    assign f          = cmd_fields_t'(cmd_word);
    assign unused_rsv = f.rsv_hi ^ f.rsv_lo ^ (^offs[15:5]);
    assign in_range   = (f.regno >= REG_BASE) && ({1'b0, f.regno} < REG_END);
    assign size_ok    = (f.size == 3'd2) || (f.size == 3'd3);
    assign offs       = f.regno - REG_BASE;

    always_comb begin
        dec.ok    = (f.ctype == 8'd0) && (!f.xfer || (in_range && size_ok));
        dec.rd    = offs[4:0];
        dec.dword = f.size[0];
        dec.wr    = f.wr;
        dec.xfer  = f.xfer;
        dec.post  = f.post;
    end
endmodule

// File: rtl/abs_slot_build.sv
module abs_slot_build
    import abs_cmd_pkg::*;
#(
    parameter logic [11:0] DATA_IMM = 12'h380,
    parameter logic [20:0] JAL_OFF  = 21'd4
) (
    input  dec_t        dec,
    output logic [31:0] slot0,
    output logic [31:0] slot1
);
    always_comb begin
        if (!dec.xfer)
            slot0 = INSN_NOP;
        else if (dec.wr)
            slot0 = enc_load(dec.rd, dec.dword, DATA_IMM);
        else
            slot0 = enc_store(dec.rd, dec.dword, DATA_IMM);
        slot1 = dec.post ? enc_jal0(JAL_OFF) : INSN_EBRK;
    end
endmodule

// File: rtl/abs_go_flags.sv
module abs_go_flags #(
    parameter int NHART  = 4,
    parameter int HART_W = (NHART > 1) ? $clog2(NHART) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [HART_W-1:0] sel,
    input  logic [NHART-1:0]  ack,
    output logic [NHART-1:0]  go
);
    for (genvar i = 0; i < NHART; i++) begin : g_hart
        always_ff @(posedge clk) begin
            if (rst)
                go[i] <= 1'b0;
            else if (set_en && (sel == HART_W'(i)))
                go[i] <= 1'b1;
            else if (ack[i])
                go[i] <= 1'b0;
        end
    end

    assert_go_onehot0_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go));
endmodule

// File: rtl/abs_cmd_seq.sv
module abs_cmd_seq
    import abs_cmd_pkg::*;
#(
    parameter int          NHART     = 4,
    parameter int          HART_W    = (NHART > 1) ? $clog2(NHART) : 1,
    parameter int          PROGBUF_N = 2,
    parameter int          ABS_WORDS = 2,
    parameter logic [11:0] DATA_IMM  = 12'h380
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_word,
    input  logic [HART_W-1:0] hart_sel,
    input  logic [NHART-1:0]  go_ack,
    input  logic              err_clr,
    output logic [31:0]       abs_slot0,
    output logic [31:0]       abs_slot1,
    output logic [2:0]        cmderr,
    output logic [NHART-1:0]  go_flags
);
    localparam int PB_START  = int'(DATA_IMM) - (4 + 4 * PROGBUF_N);
    localparam int ABS_START = PB_START - 4 * ABS_WORDS;
    localparam int JUMP      = PB_START - ABS_START - 4;
    localparam logic [20:0] JAL_OFF = 21'(JUMP);

    dec_t        dec;
    logic [31:0] nxt0, nxt1;
    cmderr_e     err_q;
    logic        busy, accept;

    abs_cmd_decode u_dec (
        .cmd_word (cmd_word),
        .dec      (dec)
    );

    abs_slot_build #(.DATA_IMM(DATA_IMM), .JAL_OFF(JAL_OFF)) u_build (
        .dec   (dec),
        .slot0 (nxt0),
        .slot1 (nxt1)
    );

    assign busy   = |go_flags;
    assign accept = cmd_valid && (err_q == ERR_NONE) && !busy && dec.ok;

    abs_go_flags #(.NHART(NHART), .HART_W(HART_W)) u_go (
        .clk    (clk),
        .rst    (rst),
        .set_en (accept),
        .sel    (hart_sel),
        .ack    (go_ack),
        .go     (go_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            abs_slot0 <= INSN_NOP;
            abs_slot1 <= INSN_EBRK;
            err_q     <= ERR_NONE;
        end else if (cmd_valid && (err_q == ERR_NONE)) begin
            if (busy)
                err_q <= ERR_BUSY;
            else if (!dec.ok)
                err_q <= ERR_NOTSUP;
            else begin
                abs_slot0 <= nxt0;
                abs_slot1 <= nxt1;
            end
        end else if (err_clr) begin
            err_q <= ERR_NONE;
        end
    end

    assign cmderr = err_q;

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> ($stable(abs_slot0) && $stable(abs_slot1)));

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmderr != 3'd0)) |=> ($stable(abs_slot0) && $stable(abs_slot1)));

    assert_go_clean_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(|go_flags) |-> ($past(cmderr) == 3'd0));

    assert_slot0_opc_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (abs_slot0[6:0] == OPC_LOAD || abs_slot0[6:0] == OPC_STORE
                    || abs_slot0 == INSN_NOP));

    assert_slot1_kind_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (abs_slot1 == INSN_EBRK || abs_slot1[6:0] == OPC_JAL));
endmodule

// File: tb/abs_cmd_seq_bench.sv
`timescale 1ns/1ps
module abs_cmd_seq_bench;
    localparam int NHART = 4;
    localparam int ABSW  = 2;
    localparam logic [11:0] DIMM = 12'h380;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_valid = 0;
    logic [31:0] cmd_word = 0;
    logic [1:0]  hart_sel = 0;
    logic [3:0]  go_ack = 0;
    logic        err_clr = 0;
    logic [31:0] abs_slot0, abs_slot1;
    logic [2:0]  cmderr;
    logic [3:0]  go_flags;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_s0, m_s1;
    int          m_err;
    logic [3:0]  m_go;

    always #2.5 clk = ~clk;

    abs_cmd_seq u_abs_cmd_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .hart_sel(hart_sel), .go_ack(go_ack), .err_clr(err_clr),
        .abs_slot0(abs_slot0), .abs_slot1(abs_slot1),
        .cmderr(cmderr), .go_flags(go_flags)
    );

    function automatic logic [31:0] mk(input int ty, input int sz, input bit post,
                                       input bit xfer, input bit wr, input int regno);
        logic [31:0] c;
        c = 0;
        c[31:24] = 8'(ty);
        c[22:20] = 3'(sz);
        c[18] = post; c[17] = xfer; c[16] = wr;
        c[15:0] = 16'(regno);
        return c;
    endfunction

    function automatic logic [31:0] exp_jal();
        logic [20:0] j;
        j = 21'(4 * ABSW - 4);
        return {j[20], j[10:1], j[11], j[19:12], 5'd0, 7'b1101111};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int old_err = m_err;
        bit busy = (m_go != 0);
        int ty  = int'(cmd_word[31:24]);
        int sz  = int'(cmd_word[22:20]);
        int rn  = int'(cmd_word[15:0]);
        bit xf  = cmd_word[17];
        bit wr  = cmd_word[16];
        bit pe  = cmd_word[18];
        logic [4:0] r;
        logic [2:0] f3;
        m_go = m_go & ~go_ack;
        if (cmd_valid && old_err == 0) begin
            if (busy) m_err = 1;
            else if (ty != 0 || (xf && (rn < 4096 || rn > 4127 || (sz != 2 && sz != 3))))
                m_err = 2;
            else begin
                r  = 5'(rn - 4096);
                f3 = (sz == 3) ? 3'b011 : 3'b010;
                if (!xf)     m_s0 = 32'h0000_0013;
                else if (wr) m_s0 = {DIMM, 5'd0, f3, r, 7'b0000011};
                else         m_s0 = {DIMM[11:5], r, 5'd0, f3, DIMM[4:0], 7'b0100011};
                m_s1 = pe ? exp_jal() : 32'h0010_0073;
                m_go[hart_sel] = 1'b1;
            end
        end else if (err_clr) m_err = 0;
    endtask

    task automatic cyc(input string tag, input bit v, input logic [31:0] c,
                       input int hs, input logic [3:0] ack, input bit clr);
        cmd_valid = v; cmd_word = c; hart_sel = 2'(hs); go_ack = ack; err_clr = clr;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        chk(tag, "slot0", abs_slot0, m_s0);
        chk(tag, "slot1", abs_slot1, m_s1);
        chk(tag, "cmderr", {29'd0, cmderr}, 32'(m_err));
        chk(tag, "go", {28'd0, go_flags}, {28'd0, m_go});
    endtask

    task automatic idle(input string tag); cyc(tag, 0, 0, 0, 4'd0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_s0 = 32'h0000_0013; m_s1 = 32'h0010_0073; m_err = 0; m_go = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "slot0", abs_slot0, 32'h0000_0013);
        chk("R1", "slot1", abs_slot1, 32'h0010_0073);
        chk("R1", "cmderr", {29'd0, cmderr}, 0);
        chk("R1", "go", {28'd0, go_flags}, 0);

        // R5/R4/R3: word load into x5, hart 1
        cyc("R5", 1, mk(0, 2, 0, 1, 1, 'h1005), 1, 4'd0, 0);
        chk("R5", "lw x5 literal", abs_slot0, 32'h3800_2283);
        chk("R8", "go hart1", {28'd0, go_flags}, 32'h2);
        cyc("R8", 0, 0, 0, 4'b0010, 0);
        chk("R8", "go cleared", {28'd0, go_flags}, 0);

        // R6: doubleword store of x31 with post-exec jump
        cyc("R6", 1, mk(0, 3, 1, 1, 0, 'h101F), 2, 4'd0, 0);
        chk("R6", "jal literal", abs_slot1, 32'h0040_006F);
        // R9: busy refusal
        cyc("R9", 1, mk(0, 2, 0, 1, 1, 'h1001), 0, 4'd0, 0);
        chk("R9", "busy err", {29'd0, cmderr}, 1);
        cyc("R10", 1, mk(0, 2, 0, 1, 1, 'h1002), 0, 4'b0100, 0);
        cyc("R10", 0, 0, 0, 4'd0, 1);
        chk("R10", "cleared", {29'd0, cmderr}, 0);

        // R3 range edges
        cyc("R3", 1, mk(0, 2, 0, 1, 1, 'h1020), 0, 4'd0, 0);
        chk("R3", "above range", {29'd0, cmderr}, 2);
        cyc("R3", 0, 0, 0, 4'd0, 1);
        cyc("R3", 1, mk(0, 2, 0, 1, 1, 'h0FFF), 0, 4'd0, 0);
        cyc("R3", 0, 0, 0, 4'd0, 1);
        cyc("R3", 1, mk(0, 2, 0, 1, 0, 'h1000), 3, 4'd0, 0);
        cyc("R3", 0, 0, 0, 4'b1000, 0);

        // R4 bad sizes
        for (int s = 0; s < 8; s++) begin
            if (s == 2 || s == 3) continue;
            cyc("R4", 1, mk(0, s, 0, 1, 1, 'h1003), 0, 4'd0, 0);
            cyc("R4", 0, 0, 0, 4'd0, 1);
        end

        // R2 non-register command, then R10 ignored while error
        cyc("R2", 1, mk(1, 2, 0, 1, 1, 'h1004), 0, 4'd0, 0);
        chk("R2", "notsup", {29'd0, cmderr}, 2);
        cyc("R10", 1, mk(0, 2, 0, 1, 1, 'h1006), 0, 4'd0, 0);
        chk("R10", "no go", {28'd0, go_flags}, 0);
        idle("R10");
        cyc("R10", 0, 0, 0, 4'd0, 1);

        // R7 transfer off: bad regno and size ignored, post-exec kept
        cyc("R7", 1, mk(0, 7, 1, 0, 1, 'h0042), 0, 4'd0, 0);
        chk("R7", "nop slot0", abs_slot0, 32'h0000_0013);
        cyc("R7", 0, 0, 0, 4'b0001, 0);
        cyc("R7", 1, mk(0, 5, 0, 0, 0, 'hFFFF), 2, 4'd0, 0);
        cyc("R7", 0, 0, 0, 4'b0100, 0);

        // R5 doubleword load and word store, no post-exec
        cyc("R5", 1, mk(0, 3, 0, 1, 1, 'h100A), 1, 4'd0, 0);
        cyc("R5", 0, 0, 0, 4'b0010, 0);
        cyc("R5", 1, mk(0, 2, 0, 1, 0, 'h1011), 0, 4'd0, 0);
        idle("R5");
        cyc("R5", 0, 0, 0, 4'b0001, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule